// File: doc/BRIEF.md
# Pipelined Zero-Turnaround Synchronous Memory Core

This block is a synthesizable behavioural model of a synchronous pipelined memory. Its data bus never needs an idle cycle when traffic switches between reads and writes. Every command input is captured on the rising clock edge. A read returns its word through an output register one edge after its address is captured. A write takes its data two edges after its address, so the bus slot that follows a read is free for the write data. Deselect cycles travel through the same pipeline, and the output stops driving one edge after the deselect. The block is intended for use as a memory model in a larger chip, or as a stand-in for an external memory of this kind.

The command pipeline is a three-state machine whose state is the operation latched at the last enabled edge: `OP_IDLE` (deselected), `OP_READ` or `OP_WRITE`. While the load strobe `ld_n` is low, an edge takes one of three load transitions. LOAD_DESEL goes to `OP_IDLE` whenever any chip enable is inactive. LOAD_READ goes to `OP_READ` when all chip enables are active and `wr_n` is high. LOAD_WRITE goes to `OP_WRITE` when all chip enables are active and `wr_n` is low. While `ld_n` is high, the ADVANCE transition keeps the current state. From `OP_READ` or `OP_WRITE`, ADVANCE also steps a two-bit burst counter over the two lowest address bits. From `OP_IDLE`, ADVANCE has no other effect.

The global clock enable `cke_n` freezes the whole pipeline. The output enable `oe_n` acts without a clock. The output is modelled as a data word `rdata` together with a drive flag `rdata_oe`; it is not a tri-state pin.

Top module: `pipe_sram_core`

## Requirements
- R1: While reset is asserted, and after its release until a read has completed, `rdata_oe` is 0. The memory contents reset to zero.
- R2: A read takes its address at edge n, when `cke_n`=0, `cs0_n`=0, `cs1`=1, `cs2_n`=0, `wr_n`=1 and `ld_n`=0. After edge n+1, `rdata` holds the word at that address.
- R3: `rdata_oe` equals the registered read-valid state ANDed with `oe_n` low. It follows changes on `oe_n` with no clock edge.
- R4: A write takes its address and its active-low byte enables `byte_we_n` at edge n. Bit i of `byte_we_n` controls data bits [8i+7:8i]. The write samples `wdata` at edge n+2 and updates only the enabled bytes.
- R5: A read whose address matches a write still in flight returns that write's enabled bytes merged with the stored bytes.
- R6: When `cke_n`=1 at an edge, no operation issues or advances. `rdata`, `rdata_oe` and all pipeline state remain unchanged.
- R7: With `ld_n`=0, any inactive chip enable at edge n makes that edge a deselect. The deselect accesses nothing, and `rdata_oe` is 0 after edge n+1.
- R8: After the edge that follows a write's address edge, `rdata_oe` is 0 whatever the value of `oe_n`.
- R9: With `ld_n`=1 after a read or write, the same operation continues at the next burst address. Only the low two address bits change, and they wrap. With `burst_ilv`=0 at the load, the k-th beat uses base+k mod 4. With `burst_ilv`=1, it uses base XOR k.
- R10: With `ld_n`=1 after a deselect, the block stays deselected. A new access needs `ld_n`=0.
- R11: Any mix of reads, writes and deselects can be issued on consecutive edges with no idle cycles, and each result matches a sequential model of the memory.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge active |
| rst_n | input | 1 | Asynchronous reset, active low |
| cke_n | input | 1 | Clock enable, active low; high freezes everything |
| cs0_n | input | 1 | Chip enable, active low |
| cs1 | input | 1 | Chip enable, active high |
| cs2_n | input | 1 | Chip enable, active low |
| wr_n | input | 1 | Write when low, read when high; taken at a load |
| byte_we_n | input | NBYTES | Per-byte write enables, active low, taken with the address |
| ld_n | input | 1 | Low loads a new command; high advances the burst |
| burst_ilv | input | 1 | Burst order taken at a load: 0 linear, 1 interleaved |
| addr | input | ADDR_W | Word address |
| wdata | input | DATA_W | Write data, sampled two edges after its address |
| oe_n | input | 1 | Output enable, active low, not clocked |
| rdata | output | DATA_W | Registered read data |
| rdata_oe | output | 1 | High while the model drives `rdata` |

## Verification
Read data and its drive flag are due after the edge that follows the read's address edge. The bench therefore samples them on the falling edge after that second rising edge. Write data is applied two edges after the write address, and its effect shows up in a later read. The checks use a reference model that steps once per enabled edge, in the order "commit the write at the back of the pipe, load the read word, shift, decode the new command". Every falling-edge sample is compared against that model's state. The asynchronous output enable is checked separately, within one edge, by toggling `oe_n` between two samples with no clock edge in between.

// File: rtl/pipe_sram_pkg.sv
package pipe_sram_pkg;
    typedef enum logic [1:0] {
        OP_IDLE  = 2'd0,
        OP_READ  = 2'd1,
        OP_WRITE = 2'd2
    } op_e;
endpackage

// File: rtl/pipe_sram_ctrl.sv
module pipe_sram_ctrl
    import pipe_sram_pkg::*;
#(
    parameter int ADDR_W = 4,
    parameter int NBYTES = 4
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              cke_n,
    input  logic              sel_ok,
    input  logic              wr_n,
    input  logic              ld_n,
    input  logic              ilv,
    input  logic [ADDR_W-1:0] addr,
    input  logic [NBYTES-1:0] byte_we_n,
    output op_e               s1_op,
    output logic [ADDR_W-1:0] s1_addr,
    output op_e               s2_op,
    output logic [ADDR_W-1:0] s2_addr,
    output logic [NBYTES-1:0] s2_be
);
    op_e               state_q, state_d;
    logic [ADDR_W-1:0] addr_q, addr_d;
    logic [1:0]        base_q, base_d, cnt_q, cnt_d;
    logic              ilv_q, ilv_d;
    logic [NBYTES-1:0] be_q;

    // next-state: load transitions when ld_n low, advance otherwise
    always_comb begin
        state_d = state_q;
        addr_d  = addr_q;
        base_d  = base_q;
        cnt_d   = cnt_q;
        ilv_d   = ilv_q;
        if (!ld_n) begin
            state_d = !sel_ok ? OP_IDLE : (wr_n ? OP_READ : OP_WRITE);
            addr_d  = addr;
            base_d  = addr[1:0];
            cnt_d   = 2'd0;
            ilv_d   = ilv;
        end else begin
            unique case (state_q)
                OP_IDLE: state_d = OP_IDLE;
                OP_READ, OP_WRITE: begin
                    state_d = state_q;
                    cnt_d   = cnt_q + 2'd1;
                    addr_d  = {addr_q[ADDR_W-1:2],
                               (ilv_q ? (base_q ^ cnt_d) : (base_q + cnt_d))};
                end
                default: state_d = OP_IDLE;
            endcase
        end
    end

    // state register
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            state_q <= OP_IDLE;
            addr_q  <= '0;
            base_q  <= '0;
            cnt_q   <= '0;
            ilv_q   <= 1'b0;
        end else if (!cke_n) begin
            state_q <= state_d;
            addr_q  <= addr_d;
            base_q  <= base_d;
            cnt_q   <= cnt_d;
            ilv_q   <= ilv_d;
        end
    end

    // outputs: byte enables of issued command and the write-data stage
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            be_q    <= '0;
            s2_op   <= OP_IDLE;
            s2_addr <= '0;
            s2_be   <= '0;
        end else if (!cke_n) begin
            be_q    <= ~byte_we_n;
            s2_op   <= state_q;
            s2_addr <= addr_q;
            s2_be   <= be_q;
        end
    end

    assign s1_op   = state_q;
    assign s1_addr = addr_q;
endmodule

// File: rtl/pipe_sram_array.sv
module pipe_sram_array #(
    parameter int ADDR_W = 4,
    parameter int NBYTES = 4,
    parameter int BYTE_W = 8
) (
    input  logic                     clk,
    input  logic                     rst_n,
    input  logic                     wr_en,
    input  logic [ADDR_W-1:0]        wr_addr,
    input  logic [NBYTES-1:0]        wr_be,
    input  logic [NBYTES*BYTE_W-1:0] wr_data,
    input  logic [ADDR_W-1:0]        rd_addr,
    output logic [NBYTES*BYTE_W-1:0] rd_data
);
    localparam int DEPTH = 1 << ADDR_W;

    for (genvar b = 0; b < NBYTES; b++) begin : g_lane
        logic [BYTE_W-1:0] lane_q [DEPTH];

        always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n) begin
                for (int i = 0; i < DEPTH; i++) lane_q[i] <= '0;
            end else if (wr_en && wr_be[b]) begin
                lane_q[wr_addr] <= wr_data[b*BYTE_W +: BYTE_W];
            end
        end

        assign rd_data[b*BYTE_W +: BYTE_W] = lane_q[rd_addr];
    end
endmodule

// File: rtl/pipe_sram_outreg.sv
module pipe_sram_outreg #(
    parameter int NBYTES = 4,
    parameter int BYTE_W = 8
) (
    input  logic                     clk,
    input  logic                     rst_n,
    input  logic                     cke_n,
    input  logic                     rd_req,
    input  logic                     fwd_hit,
    input  logic [NBYTES-1:0]        fwd_be,
    input  logic [NBYTES*BYTE_W-1:0] fwd_data,
    input  logic [NBYTES*BYTE_W-1:0] mem_word,
    input  logic                     oe_n,
    output logic [NBYTES*BYTE_W-1:0] rdata,
    output logic                     valid_q,
    output logic                     rdata_oe
);
    logic [NBYTES*BYTE_W-1:0] merged;

    for (genvar b = 0; b < NBYTES; b++) begin : g_merge
        assign merged[b*BYTE_W +: BYTE_W] = (fwd_hit && fwd_be[b])
                                            ? fwd_data[b*BYTE_W +: BYTE_W]
                                            : mem_word[b*BYTE_W +: BYTE_W];
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            valid_q <= 1'b0;
            rdata   <= '0;
        end else if (!cke_n) begin
            valid_q <= rd_req;
            if (rd_req) rdata <= merged;
        end
    end

    assign rdata_oe = valid_q & ~oe_n;
endmodule

// File: rtl/pipe_sram_core.sv
module pipe_sram_core
    import pipe_sram_pkg::*;
#(
    parameter int ADDR_W = 4,
    parameter int NBYTES = 4,
    parameter int BYTE_W = 8,
    localparam int DATA_W = NBYTES * BYTE_W
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              cke_n,
    input  logic              cs0_n,
    input  logic              cs1,
    input  logic              cs2_n,
    input  logic              wr_n,
    input  logic [NBYTES-1:0] byte_we_n,
    input  logic              ld_n,
    input  logic              burst_ilv,
    input  logic [ADDR_W-1:0] addr,
    input  logic [DATA_W-1:0] wdata,
    input  logic              oe_n,
    output logic [DATA_W-1:0] rdata,
    output logic              rdata_oe
);
    op_e               s1_op, s2_op;
    logic [ADDR_W-1:0] s1_addr, s2_addr;
    logic [NBYTES-1:0] s2_be;
    logic [DATA_W-1:0] mem_word;
    logic              sel_ok, wr_en, fwd_hit, rd_valid;

    assign sel_ok  = !cs0_n && cs1 && !cs2_n;
    assign wr_en   = !cke_n && (s2_op == OP_WRITE);
    assign fwd_hit = (s2_op == OP_WRITE) && (s2_addr == s1_addr);

    pipe_sram_ctrl #(.ADDR_W(ADDR_W), .NBYTES(NBYTES)) u_ctrl (
        .clk(clk), .rst_n(rst_n), .cke_n(cke_n), .sel_ok(sel_ok),
        .wr_n(wr_n), .ld_n(ld_n), .ilv(burst_ilv), .addr(addr),
        .byte_we_n(byte_we_n), .s1_op(s1_op), .s1_addr(s1_addr),
        .s2_op(s2_op), .s2_addr(s2_addr), .s2_be(s2_be)
    );

    pipe_sram_array #(.ADDR_W(ADDR_W), .NBYTES(NBYTES), .BYTE_W(BYTE_W)) u_array (
        .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .wr_addr(s2_addr),
        .wr_be(s2_be), .wr_data(wdata), .rd_addr(s1_addr), .rd_data(mem_word)
    );

    pipe_sram_outreg #(.NBYTES(NBYTES), .BYTE_W(BYTE_W)) u_out (
        .clk(clk), .rst_n(rst_n), .cke_n(cke_n),
        .rd_req(s1_op == OP_READ), .fwd_hit(fwd_hit), .fwd_be(s2_be),
        .fwd_data(wdata), .mem_word(mem_word), .oe_n(oe_n),
        .rdata(rdata), .valid_q(rd_valid), .rdata_oe(rdata_oe)
    );
endmodule

// File: rtl/pipe_sram_chk.sv
module pipe_sram_chk
    import pipe_sram_pkg::*;
#(
    parameter int DATA_W = 32
) (
    input logic              clk,
    input logic              rst_n,
    input logic              cke_n,
    input logic              ld_n,
    input logic              oe_n,
    input logic [DATA_W-1:0] rdata,
    input logic              rdata_oe,
    input logic              rd_valid,
    input op_e               s1_op
);
    always_comb begin
        if (!rst_n) a_r1_quiet_in_reset: assert (!rdata_oe);
    end

    a_r3_oe_gates: assert property (@(posedge clk) disable iff (!rst_n)
        oe_n |-> !rdata_oe);

    a_r2_read_valid: assert property (@(posedge clk) disable iff (!rst_n)
        (!cke_n && s1_op == OP_READ) |=> rd_valid);

    a_r6_freeze: assert property (@(posedge clk) disable iff (!rst_n)
        cke_n |=> ($stable(rdata) && $stable(rd_valid) && $stable(s1_op)));

    a_r7_deselect_release: assert property (@(posedge clk) disable iff (!rst_n)
        (!cke_n && s1_op == OP_IDLE) |=> !rdata_oe);

    a_r8_write_no_drive: assert property (@(posedge clk) disable iff (!rst_n)
        (!cke_n && s1_op == OP_WRITE) |=> !rdata_oe);

    a_r10_stay_idle: assert property (@(posedge clk) disable iff (!rst_n)
        (!cke_n && ld_n && s1_op == OP_IDLE) |=> (s1_op == OP_IDLE));
endmodule

bind pipe_sram_core pipe_sram_chk #(.DATA_W(DATA_W)) u_chk (
    .clk(clk), .rst_n(rst_n), .cke_n(cke_n), .ld_n(ld_n), .oe_n(oe_n),
    .rdata(rdata), .rdata_oe(rdata_oe), .rd_valid(rd_valid), .s1_op(s1_op)
);

// File: tb/pipe_sram_core_tb.sv
module pipe_sram_core_tb;
    localparam int AW = 4;
    localparam int NB = 4;
    localparam int DW = NB * 8;
    localparam int DEPTH = 1 << AW;

    logic clk = 1'b0, rst_n = 1'b0;
    logic cke_n = 1'b0, cs0_n = 1'b1, cs1 = 1'b0, cs2_n = 1'b1;
    logic wr_n = 1'b1, ld_n = 1'b0, burst_ilv = 1'b0, oe_n = 1'b0;
    logic [NB-1:0] byte_we_n = '1;
    logic [AW-1:0] addr = '0;
    logic [DW-1:0] wdata = '0;
    logic [DW-1:0] rdata;
    logic          rdata_oe;

    int checks = 0, fails = 0;
    bit done = 1'b0;

    // reference model state (0 idle, 1 read, 2 write)
    int            m_s1op = 0, m_s2op = 0;
    logic [AW-1:0] m_s1addr = '0, m_s2addr = '0;
    logic [NB-1:0] m_s1be = '0, m_s2be = '0;
    logic [1:0]    m_base = '0, m_cnt = '0;
    bit            m_ilv = 1'b0, m_valid = 1'b0;
    logic [DW-1:0] m_rdata = '0;
    logic [DW-1:0] m_mem [DEPTH];

    always #2.5 clk = ~clk;

    pipe_sram_core u_dut (
        .clk(clk), .rst_n(rst_n), .cke_n(cke_n), .cs0_n(cs0_n), .cs1(cs1),
        .cs2_n(cs2_n), .wr_n(wr_n), .byte_we_n(byte_we_n), .ld_n(ld_n),
        .burst_ilv(burst_ilv), .addr(addr), .wdata(wdata), .oe_n(oe_n),
        .rdata(rdata), .rdata_oe(rdata_oe)
    );

    function automatic logic [1:0] burst_lo(logic [1:0] base, logic [1:0] k, bit ilv);
        return ilv ? (base ^ k) : (base + k);
    endfunction

    task automatic model_step();
        bit sel;
        if (cke_n) return;
        if (m_s2op == 2)
            for (int b = 0; b < NB; b++)
                if (m_s2be[b]) m_mem[m_s2addr][b*8 +: 8] = wdata[b*8 +: 8];
        m_valid = (m_s1op == 1);
        if (m_valid) m_rdata = m_mem[m_s1addr];
        m_s2op = m_s1op; m_s2addr = m_s1addr; m_s2be = m_s1be;
        sel = !cs0_n && cs1 && !cs2_n;
        if (!ld_n) begin
            m_s1op = !sel ? 0 : (wr_n ? 1 : 2);
            m_s1addr = addr; m_base = addr[1:0]; m_cnt = 2'd0; m_ilv = burst_ilv;
        end else if (m_s1op != 0) begin
            m_cnt = m_cnt + 2'd1;
            m_s1addr[1:0] = burst_lo(m_base, m_cnt, m_ilv);
        end
        m_s1be = ~byte_we_n;
    endtask

    task automatic check_out(string tag);
        bit exp_oe;
        exp_oe = m_valid && !oe_n;
        checks++;
        if (rdata_oe !== exp_oe) begin
            fails++;
            $display("FAIL %s rdata_oe got %0b expected %0b", tag, rdata_oe, exp_oe);
        end
        if (exp_oe) begin
            checks++;
            if (rdata !== m_rdata) begin
                fails++;
                $display("FAIL %s rdata got %h expected %h", tag, rdata, m_rdata);
            end
        end
    endtask

    task automatic cyc(bit ckn, bit ok, bit wr, bit ld, bit ilv, logic [AW-1:0] a,
                       logic [NB-1:0] ben, logic [DW-1:0] wd, bit oen, string tag);
        cke_n = ckn; wr_n = !wr; ld_n = !ld; burst_ilv = ilv; addr = a;
        byte_we_n = ben; wdata = wd; oe_n = oen;
        {cs0_n, cs1, cs2_n} = 3'b010;
        if (!ok) begin
            case ($urandom_range(0, 2))
                0: cs0_n = 1'b1;
                1: cs1 = 1'b0;
                default: cs2_n = 1'b1;
            endcase
        end
        model_step();
        @(negedge clk);
        check_out(tag);
    endtask

    initial begin
        repeat (150000) @(posedge clk);
        if (!done) begin
            fails++;
            $display("FAIL watchdog expired");
            $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
            $finish;
        end
    end

    initial begin
        void'($urandom(32'h5EED_0042));
        for (int i = 0; i < DEPTH; i++) m_mem[i] = '0;
        repeat (3) @(negedge clk);
        check_out("R1");
        rst_n = 1'b1;
        check_out("R1");

        // R1: reset contents are zero
        cyc(0, 1, 0, 1, 0, 4'd3, 4'h0, 0, 0, "R1");
        cyc(0, 0, 0, 1, 0, 4'd0, 4'h0, 0, 0, "R1");
        cyc(0, 0, 0, 1, 0, 4'd0, 4'h0, 0, 0, "R1");
        // R4/R8: back-to-back writes, data two edges later
        cyc(0, 1, 1, 1, 0, 4'd1, 4'h0, 0, 0, "R8");
        cyc(0, 1, 1, 1, 0, 4'd2, 4'h0, 0, 0, "R8");
        cyc(0, 1, 0, 1, 0, 4'd1, 4'h0, 32'hA1A1_0101, 0, "R4");
        cyc(0, 1, 0, 1, 0, 4'd2, 4'h0, 32'hB2B2_0202, 0, "R2");
        cyc(0, 1, 1, 1, 0, 4'd2, 4'b0101, 0, 0, "R2");
        cyc(0, 0, 0, 1, 0, 4'd0, 4'h0, 0, 0, "R4");
        cyc(0, 1, 0, 1, 0, 4'd2, 4'h0, 32'hFFEE_DDCC, 0, "R4");
        cyc(0, 0, 0, 1, 0, 4'd0, 4'h0, 0, 0, "R4");
        // R5: write then read of same address on the next edge
        cyc(0, 1, 1, 1, 0, 4'd5, 4'h0, 0, 0, "R5");
        cyc(0, 1, 1, 1, 0, 4'd5, 4'b1010, 32'h1111_1111, 0, "R5");
        cyc(0, 1, 0, 1, 0, 4'd5, 4'h0, 32'h1234_5678, 0, "R5");
        cyc(0, 1, 0, 1, 0, 4'd5, 4'h0, 32'hCAFE_F00D, 0, "R5");
        cyc(0, 0, 0, 1, 0, 4'd0, 4'h0, 0, 0, "R5");
        // R9: linear then interleaved bursts from base 9
        for (int i = 0; i < DEPTH; i++) begin
            cyc(0, 1, 1, 1, 0, 4'(i), 4'h0, 0, 0, "R11");
            cyc(0, 0, 0, 1, 0, 4'd0, 4'h0, 0, 0, "R11");
            cyc(0, 0, 0, 1, 0, 4'd0, 4'h0, 32'h0100_0000 * i + 32'h0000_AB00 + i, 0, "R11");
        end
        cyc(0, 1, 0, 1, 0, 4'd9, 4'h0, 0, 0, "R9");
        for (int k = 0; k < 5; k++) cyc(0, 0, 0, 0, 0, 4'd0, 4'h0, 0, 0, "R9");
        cyc(0, 1, 0, 1, 1, 4'd9, 4'h0, 0, 0, "R9");
        for (int k = 0; k < 5; k++) cyc(0, 0, 0, 0, 0, 4'd0, 4'h0, 0, 0, "R9");
        // R6: clock enable held high in mid burst
        cyc(0, 1, 0, 1, 0, 4'd6, 4'h0, 0, 0, "R6");
        cyc(0, 1, 0, 0, 0, 4'd0, 4'h0, 0, 0, "R6");
        for (int k = 0; k < 3; k++) cyc(1, 0, 1, 1, 1, 4'd12, 4'h0, 32'hDEAD_BEEF, 0, "R6");
        cyc(0, 1, 0, 0, 0, 4'd0, 4'h0, 0, 0, "R6");
        // R7/R10: deselect, then advance stays idle
        cyc(0, 0, 0, 1, 0, 4'd3, 4'h0, 0, 0, "R7");
        cyc(0, 1, 0, 0, 0, 4'd3, 4'h0, 0, 0, "R7");
        cyc(0, 1, 0, 0, 0, 4'd3, 4'h0, 0, 0, "R10");
        cyc(0, 1, 0, 1, 0, 4'd3, 4'h0, 0, 0, "R10");
        cyc(0, 0, 0, 1, 0, 4'd0, 4'h0, 0, 0, "R10");
        // R3: output enable acts without a clock edge
        cyc(0, 1, 0, 1, 0, 4'd7, 4'h0, 0, 0, "R3");
        cyc(0, 0, 0, 1, 0, 4'd0, 4'h0, 0, 1, "R3");
        oe_n = 1'b0; #1; check_out("R3");
        oe_n = 1'b1; #1; check_out("R3");
        // R11: constrained random mix
        for (int n = 0; n < 4000; n++) begin
            cyc($urandom_range(0, 9) == 0, $urandom_range(0, 7) != 0,
                $urandom_range(0, 1) == 1, $urandom_range(0, 3) != 0,
                $urandom_range(0, 1) == 1, 4'($urandom), 4'($urandom),
                $urandom, $urandom_range(0, 4) == 0, "R11");
        end
        done = 1'b1;
        $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
        $finish;
    end
endmodule